// File: doc/BRIEF.md
# Serial-EEPROM Station Address Loader

After every hard reset this block fetches the first sixteen bytes of an attached three-wire serial EEPROM and places them in a sixteen-byte station-address PROM area. While it stores them, it also copies the first six bytes into three 16-bit physical-address registers. Once the area is full, it checks two things over fixed byte positions and reports each as a flag: a stored 16-bit checksum, and a two-byte signature.

The host can read the PROM area one byte or one word at a time. It can write the area one byte at a time, but only when a write-enable bit is set. These writes only change values that software reads. They never reach the physical-address registers or the check flags. While the load is running, reads return zero and host writes are dropped.

Top module: `sa_prom_loader`

## Requirements
- R1: After rst_ni deasserts, the block reads EEPROM words 0 to 7 in that order, one serial transaction per word, and does nothing else on the EEPROM. Each transaction works as follows. ee_cs_o goes high. On ee_di_o the block sends a start bit 1, the opcode bits 1 then 0, and a 6-bit word address with the MSB first. It then takes 16 data bits from ee_do_i, MSB first. ee_cs_o drops between transactions. After the eighth word, done_o rises, stays high, and ee_cs_o stays low.
- R2: Bits [7:0] of EEPROM word k go to PROM byte 2k, and bits [15:8] go to PROM byte 2k+1.
- R3: The physical-address registers hold the following values, low byte first:
  - phys_addr0_o = {byte1, byte0}
  - phys_addr1_o = {byte3, byte2}
  - phys_addr2_o = {byte5, byte4}
- R4: Once done, csum_ok_o is 1 exactly when {byte13, byte12} equals the sum modulo 2^16 of bytes 0 to 11, byte 14 and byte 15.
- R5: Once done, sig_ok_o is 1 exactly when byte 14 and byte 15 are both 0x57.
- R6: Reads depend on rd_word_i, with a = rd_addr_i:
  - rd_word_i = 0: rd_data_o = {8'h00, byte[a]}.
  - rd_word_i = 1: rd_data_o = {byte[a|1], byte[a&~1]}.
- R7: From reset until all 16 bytes are stored, busy_o = 1, done_o = 0, the flags read 0, and rd_data_o = 0.
- R8: When done_o = 1, wr_en_i = 1 and prom_we_i = 1, the host write sets byte[wr_addr_i] to wr_data_i. With prom_we_i = 0, or while busy, the write is ignored.
- R9: Host writes leave the physical-address registers, csum_ok_o and sig_ok_o unchanged.
- R10: If ee_do_i is stuck high (no EEPROM fitted), all 16 bytes read 0xFF and both flags are 0.
- R11: While ee_cs_o is high, ee_sk_o has a period of 2*CLK_DIV clock cycles. ee_sk_o is low whenever ee_cs_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| rd_addr_i | input | 4 | Host read byte address |
| rd_word_i | input | 1 | 1 selects a word read, 0 selects a byte read |
| rd_data_o | output | 16 | Host read data |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_addr_i | input | 4 | Host write byte address |
| wr_data_i | input | 8 | Host write data |
| prom_we_i | input | 1 | PROM write-enable control bit |
| phys_addr0_o | output | 16 | Station address bytes 1:0 |
| phys_addr1_o | output | 16 | Station address bytes 3:2 |
| phys_addr2_o | output | 16 | Station address bytes 5:4 |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished |
| csum_ok_o | output | 1 | Checksum matched |
| sig_ok_o | output | 1 | Signature matched |

## Verification
The assertions check several properties on every cycle:
- the serial clock stays low without chip select;
- done is sticky, and the EEPROM stays quiet once done;
- a write with the enable bit clear leaves the PROM untouched;
- the address registers and flags stay frozen after the load.

Some behaviours can only be shown by the bench scenarios, which use an EEPROM model with several images. These are:
- the command bit order and the word sequence;
- byte placement and the read formats;
- the checksum and signature outcomes for good, corrupted and missing EEPROMs;
- the serial clock period.

// File: rtl/sa_prom_pkg.sv
package sa_prom_pkg;
  localparam int PROM_BYTES = 16;
  localparam int PHYS_WORDS = 3;
  localparam int CSUM_LO    = 12;
  localparam int CSUM_HI    = 13;
  localparam int SIG_LO     = 14;
  localparam int SIG_HI     = 15;
  localparam logic [7:0] SIG_VAL = 8'h57;

  typedef enum logic [1:0] {CTL_REQ, CTL_WAIT, CTL_FIN, CTL_DONE} ctl_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_state_e;
endpackage

// File: rtl/sa_ee_reader.sv
module sa_ee_reader
  import sa_prom_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rdy_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int TOT_BITS = CMD_BITS + WORD_W;
  localparam int CNT_W    = $clog2(TOT_BITS);
  localparam int DIV_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  rd_state_e             state_q;
  logic [DIV_W-1:0]      div_q;
  logic [CNT_W-1:0]      bit_q;
  logic [CMD_BITS-1:0]   cmd_q;
  logic [WORD_W-1:0]     data_q;
  logic                  tick;

  assign tick  = (div_q == DIV_W'(CLK_DIV - 1));
  assign rdy_o = (state_q == RD_IDLE);
  assign word_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RD_IDLE;
      div_q      <= '0;
      bit_q      <= '0;
      cmd_q      <= '0;
      data_q     <= '0;
      word_vld_o <= 1'b0;
      ee_cs_o    <= 1'b0;
      ee_sk_o    <= 1'b0;
      ee_di_o    <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (state_q != RD_IDLE) div_q <= tick ? '0 : div_q + 1'b1;
      case (state_q)
        RD_IDLE: if (start_i) begin
          // start bit, read opcode 2'b10, then address MSB first
          cmd_q   <= {1'b1, 2'b10, addr_i} << 1;
          ee_di_o <= 1'b1;
          ee_cs_o <= 1'b1;
          ee_sk_o <= 1'b0;
          bit_q   <= '0;
          div_q   <= '0;
          state_q <= RD_SHIFT;
        end
        RD_SHIFT: if (tick) begin
          if (!ee_sk_o) begin
            ee_sk_o <= 1'b1;
          end else begin
            ee_sk_o <= 1'b0;
            if (bit_q >= CNT_W'(CMD_BITS)) data_q <= {data_q[WORD_W-2:0], ee_do_i};
            if (bit_q == CNT_W'(TOT_BITS - 1)) begin
              ee_cs_o    <= 1'b0;
              ee_di_o    <= 1'b0;
              word_vld_o <= 1'b1;
              state_q    <= RD_GAP;
            end else begin
              bit_q   <= bit_q + 1'b1;
              ee_di_o <= cmd_q[CMD_BITS-1];
              cmd_q   <= cmd_q << 1;
            end
          end
        end
        RD_GAP: if (tick) state_q <= RD_IDLE;
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  a_r11_sk_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_cs_o |-> !ee_sk_o);

  a_r1_vld_ends_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> !ee_cs_o);
endmodule

// File: rtl/sa_prom_store.sv
module sa_prom_store
  import sa_prom_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ld_we_i,
  input  logic [IDX_W-1:0]            ld_widx_i,
  input  logic [15:0]                 ld_word_i,
  input  logic                        fin_i,
  input  logic                        done_i,
  input  logic [$clog2(PROM_BYTES)-1:0] rd_addr_i,
  input  logic                        rd_word_i,
  output logic [15:0]                 rd_data_o,
  input  logic                        wr_en_i,
  input  logic [$clog2(PROM_BYTES)-1:0] wr_addr_i,
  input  logic [7:0]                  wr_data_i,
  input  logic                        prom_we_i,
  output logic [PHYS_WORDS-1:0][15:0] phys_o,
  output logic                        csum_ok_o,
  output logic                        sig_ok_o
);
  localparam int BA_W = $clog2(PROM_BYTES);

  logic [PROM_BYTES-1:0][7:0] prom_q;
  logic [15:0]                sum;
  logic                       host_wr;
  logic [BA_W-1:0]            lo_idx, hi_idx, ev_rd, od_rd;

  assign host_wr = wr_en_i && prom_we_i && done_i;
  assign lo_idx  = BA_W'({ld_widx_i, 1'b0});
  assign hi_idx  = BA_W'({ld_widx_i, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prom_q <= '0;
    end else if (ld_we_i) begin
      prom_q[lo_idx] <= ld_word_i[7:0];
      prom_q[hi_idx] <= ld_word_i[15:8];
    end else if (host_wr) begin
      prom_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < PHYS_WORDS; g++) begin : g_phys
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) phys_o[g] <= '0;
      else if (ld_we_i && ld_widx_i == IDX_W'(g)) phys_o[g] <= ld_word_i;
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < PROM_BYTES; i++)
      if (i != CSUM_LO && i != CSUM_HI) sum = sum + {8'h00, prom_q[i]};
  end

  // flags are taken once, at the end of the load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csum_ok_o <= 1'b0;
      sig_ok_o  <= 1'b0;
    end else if (fin_i) begin
      csum_ok_o <= (sum == {prom_q[CSUM_HI], prom_q[CSUM_LO]});
      sig_ok_o  <= (prom_q[SIG_LO] == SIG_VAL) && (prom_q[SIG_HI] == SIG_VAL);
    end
  end

  assign ev_rd = {rd_addr_i[BA_W-1:1], 1'b0};
  assign od_rd = {rd_addr_i[BA_W-1:1], 1'b1};

  always_comb begin
    if (!done_i)        rd_data_o = '0;
    else if (rd_word_i) rd_data_o = {prom_q[od_rd], prom_q[ev_rd]};
    else                rd_data_o = {8'h00, prom_q[rd_addr_i]};
  end

  a_r8_gated_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !prom_we_i) |=> $stable(prom_q));

  a_r9_phys_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> $stable(phys_o));

  a_r9_flags_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ($stable(csum_ok_o) && $stable(sig_ok_o)));
endmodule

// File: rtl/sa_prom_loader.sv
module sa_prom_loader
  import sa_prom_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i,
  input  logic [3:0]  rd_addr_i,
  input  logic        rd_word_i,
  output logic [15:0] rd_data_o,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        prom_we_i,
  output logic [15:0] phys_addr0_o,
  output logic [15:0] phys_addr1_o,
  output logic [15:0] phys_addr2_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        csum_ok_o,
  output logic        sig_ok_o
);
  localparam int NWORDS = PROM_BYTES / 2;
  localparam int IDX_W  = $clog2(NWORDS);

  ctl_state_e                  state_q;
  logic [IDX_W-1:0]            widx_q;
  logic                        rdy, start, vld;
  logic [15:0]                 word;
  logic [PHYS_WORDS-1:0][15:0] phys;

  assign start  = (state_q == CTL_REQ) && rdy;
  assign done_o = (state_q == CTL_DONE);
  assign busy_o = !done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CTL_REQ;
      widx_q  <= '0;
    end else begin
      case (state_q)
        CTL_REQ:  if (rdy) state_q <= CTL_WAIT;
        CTL_WAIT: if (vld) begin
          if (widx_q == IDX_W'(NWORDS - 1)) state_q <= CTL_FIN;
          else begin
            widx_q  <= widx_q + 1'b1;
            state_q <= CTL_REQ;
          end
        end
        CTL_FIN:  state_q <= CTL_DONE;
        default:  state_q <= CTL_DONE;
      endcase
    end
  end

  sa_ee_reader #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .WORD_W(16)) u_rd (
    .clk_i, .rst_ni,
    .start_i   (start),
    .addr_i    (ADDR_W'(widx_q)),
    .rdy_o     (rdy),
    .word_o    (word),
    .word_vld_o(vld),
    .ee_cs_o, .ee_sk_o, .ee_di_o, .ee_do_i
  );

  sa_prom_store #(.IDX_W(IDX_W)) u_st (
    .clk_i, .rst_ni,
    .ld_we_i   (vld && state_q == CTL_WAIT),
    .ld_widx_i (widx_q),
    .ld_word_i (word),
    .fin_i     (state_q == CTL_FIN),
    .done_i    (done_o),
    .rd_addr_i, .rd_word_i, .rd_data_o,
    .wr_en_i, .wr_addr_i, .wr_data_i, .prom_we_i,
    .phys_o    (phys),
    .csum_ok_o, .sig_ok_o
  );

  assign phys_addr0_o = phys[0];
  assign phys_addr1_o = phys[1];
  assign phys_addr2_o = phys[2];

  a_r1_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r1_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ee_cs_o && !ee_sk_o));
endmodule

// File: tb/sa_prom_loader_tb_top.sv
module sa_prom_loader_tb_top;
  localparam int DIV = 4;
  localparam logic [4:0] RD_VEC [12] = '{
    5'h00, 5'h05, 5'h0B, 5'h0F, 5'h10, 5'h13, 5'h14, 5'h17,
    5'h1A, 5'h1C, 5'h1D, 5'h0C
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ee_cs, ee_sk, ee_di, ee_do = 1'b1;
  logic [3:0] rd_addr = '0, wr_addr = '0;
  logic rd_word = 1'b0, wr_en = 1'b0, prom_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic [15:0] rd_data, pa0, pa1, pa2;
  logic busy, done, csum_ok, sig_ok;

  logic [7:0] img [16];
  logic present = 1'b1;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  sa_prom_loader #(.CLK_DIV(DIV), .ADDR_W(6)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do),
    .rd_addr_i(rd_addr), .rd_word_i(rd_word), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .prom_we_i(prom_we),
    .phys_addr0_o(pa0), .phys_addr1_o(pa1), .phys_addr2_o(pa2),
    .busy_o(busy), .done_o(done), .csum_ok_o(csum_ok), .sig_ok_o(sig_ok)
  );

  // EEPROM model and serial monitor
  logic sk_q = 1'b0, cs_q = 1'b0, seen_rise = 1'b0;
  logic [8:0] m_cmd = '0;
  int m_cnt = 0, n_tx = 0, cmd_err = 0, sk_err = 0, cyc = 0;
  always @(posedge clk) begin
    sk_q <= ee_sk;
    cs_q <= ee_cs;
    if (!rst_n) begin
      n_tx <= 0; cmd_err <= 0; sk_err <= 0; m_cnt <= 0; seen_rise <= 1'b0;
      ee_do <= 1'b1;
    end else begin
      if (ee_cs && !cs_q) n_tx <= n_tx + 1;
      if (!ee_cs && ee_sk) sk_err <= sk_err + 1;
      if (!ee_cs) begin
        m_cnt <= 0; seen_rise <= 1'b0;
      end else if (ee_sk && !sk_q) begin
        if (seen_rise && cyc != 2*DIV) sk_err <= sk_err + 1;
        seen_rise <= 1'b1;
        cyc <= 1;
        if (m_cnt < 9) m_cmd <= {m_cmd[7:0], ee_di};
        else begin
          if (m_cnt == 9 && m_cmd != {3'b110, 6'(n_tx - 1)}) cmd_err <= cmd_err + 1;
          ee_do <= present ? {img[2*m_cmd[2:0]+1], img[2*m_cmd[2:0]]}[24-m_cnt] : 1'b1;
        end
        m_cnt <= m_cnt + 1;
      end else cyc <= cyc + 1;
      if (!present) ee_do <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] v);
    logic [3:0] a = v[3:0];
    if (!present) return v[4] ? 16'hFFFF : 16'h00FF;
    if (v[4]) return {img[{a[3:1], 1'b1}], img[{a[3:1], 1'b0}]};
    return {8'h00, img[a]};
  endfunction

  task automatic fix_csum();
    logic [15:0] s = '0;
    for (int i = 0; i < 16; i++) if (i != 12 && i != 13) s = s + {8'h00, img[i]};
    img[12] = s[7:0];
    img[13] = s[15:8];
  endtask

  task automatic rd(input logic [4:0] v, output logic [15:0] d);
    @(negedge clk);
    rd_addr = v[3:0];
    rd_word = v[4];
    #2 d = rd_data;
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    wr_addr = a; wr_data = d; prom_we = en; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; prom_we = 1'b0;
  endtask

  task automatic load();
    logic [15:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'h10, d);
    chk("R7 busy at reset", {14'h0, busy, done}, 16'h2);
    chk("R7 read zero while busy", d, 16'h0000);
    chk("R7 flags clear while busy", {14'h0, csum_ok, sig_ok}, 16'h0);
    hwrite(4'd7, 8'h99, 1'b1);  // R8: dropped while busy
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk("R1 load finished", {15'h0, done}, 16'h1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    // valid image
    img = '{8'h02, 8'h1A, 8'h2B, 8'h3C, 8'h4D, 8'h5E, 8'h11, 8'h22,
            8'h33, 8'h44, 8'h55, 8'h66, 8'h00, 8'h00, 8'h57, 8'h57};
    fix_csum();
    load();
    chk("R1 eight transactions", 16'(n_tx), 16'd8);
    chk("R1 command bits and order", 16'(cmd_err), 16'd0);
    chk("R11 sk period and idle level", 16'(sk_err), 16'd0);
    chk("R3 phys0", pa0, 16'h1A02);
    chk("R3 phys1", pa1, 16'h3C2B);
    chk("R3 phys2", pa2, 16'h5E4D);
    chk("R4 csum ok", {15'h0, csum_ok}, 16'h1);
    chk("R5 sig ok", {15'h0, sig_ok}, 16'h1);
    for (int k = 0; k < 12; k++) begin
      rd(RD_VEC[k], d);
      chk("R2 R6 read vector", d, exp_rd(RD_VEC[k]));
    end
    rd(5'h07, d);
    chk("R8 busy write ignored", d, {8'h00, img[7]});
    repeat (200) @(negedge clk);
    chk("R1 no access after done", 16'(n_tx), 16'd8);

    hwrite(4'd3, 8'hAA, 1'b0);
    rd(5'h03, d);
    chk("R8 gated write ignored", d, {8'h00, 8'h3C});
    hwrite(4'd3, 8'hAA, 1'b1);
    rd(5'h03, d);
    chk("R8 enabled write", d, 16'h00AA);
    hwrite(4'd14, 8'h00, 1'b1);
    rd(5'h1E, d);
    chk("R8 enabled write word view", d, 16'h5700);
    chk("R9 phys1 unchanged", pa1, 16'h3C2B);
    chk("R9 flags unchanged", {14'h0, csum_ok, sig_ok}, 16'h3);

    // bad checksum
    img[12] = img[12] ^ 8'h01;
    load();
    chk("R4 csum bad", {15'h0, csum_ok}, 16'h0);
    chk("R5 sig still ok", {15'h0, sig_ok}, 16'h1);

    // bad signature, checksum consistent
    img[15] = 8'h58;
    fix_csum();
    load();
    chk("R5 sig bad", {15'h0, sig_ok}, 16'h0);
    chk("R4 csum ok with bad sig", {15'h0, csum_ok}, 16'h1);

    // no EEPROM fitted
    present = 1'b0;
    load();
    for (int k = 0; k < 8; k++) begin
      rd(5'(16 + 2*k), d);
      chk("R10 absent all ones", d, 16'hFFFF);
    end
    chk("R10 absent flags clear", {14'h0, csum_ok, sig_ok}, 16'h0);
    chk("R10 absent phys0", pa0, 16'hFFFF);

    summary();
    $finish;
  end
endmodule